// File: doc/BRIEF.md
# System control register block

A bank of 32-bit words behind a simple synchronous slave port. Software stores scratch and control values in it and reads them back. A small set of words has side effects:

- One control word accepts command codes that raise a one-cycle request, either to reset the system or to shut it down.
- Three status words always read with two fixed bits set.
- Four identification words come out of reset holding constant values.

The logic that carries out a reset or shutdown request sits outside this block.

The port decodes a 4 KiB byte window. Behind the window are NUM_WORDS words of storage (512 by default), indexed by byte offset divided by 4 and taken modulo NUM_WORDS. As a result the upper half of the window aliases the lower half. The command word and the forced-bit status words are matched on the full word offset, so an alias of one of them behaves as plain storage.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, word index 0x40 (byte offset 0x100) holds 0x05F20121, index 0x41 holds 0x00000002, index 0x42 holds 0x05F30121 and index 0x43 holds 0x05F40121.
- R2: After reset, every other word holds zero.
- R3: A write stores bus_wdata into word (bus_addr[10:2]). A later read of that word returns it. bus_addr[1:0] is ignored.
- R4: Byte offsets 0x800 to 0xFFF reach the same words as the offset minus 0x800.
- R5: A write of 1 or 2 to byte offset 0xF00 makes sys_reset_req high for exactly the one cycle after the write edge.
- R6: A write of 3 to byte offset 0xF00 makes sys_off_req high for exactly the one cycle after the write edge.
- R7: No other write raises either request: not another code at 0xF00, and not any value at another offset, including its alias 0x700. The written value is still stored.
- R8: Reads of byte offsets 0x100, 0x108 and 0x10C return the stored word with bits 29 and 28 set. The stored word is not changed, which shows through the alias offsets 0x900, 0x908 and 0x90C.
- R9: bus_rdata is valid in the cycle after bus_rd and holds its value until the next read.
- R10: If a read and a write hit the same word in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (12) | Byte offset within the window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (32) | Registered read data |
| sys_reset_req | output | 1 | One-cycle system reset request |
| sys_off_req | output | 1 | One-cycle shutdown request |

## Verification
A read and a write can land in the same cycle. When both target one word, the stored-value update and the read capture compete. The bench provokes this by asserting both strobes at one offset. The data returned must be the old value, and a second read must then show the new one.

A write to the command word also falls in the same cycle as its storage update. The bench therefore checks the request pulse and the stored code together: the pulse appears in the next cycle, and the code reads back afterwards.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  // word offset (byte offset / 4) of the command word
  localparam int unsigned CMD_WORD   = 'h3C0;
  localparam logic [31:0] CODE_RST_A = 32'd1;
  localparam logic [31:0] CODE_RST_B = 32'd2;
  localparam logic [31:0] CODE_OFF   = 32'd3;

  localparam logic [31:0] FORCE_MASK = 32'h3000_0000;
  localparam int unsigned NUM_FORCED = 3;
  localparam int unsigned FORCED_WORDS [NUM_FORCED] = '{'h40, 'h42, 'h43};

  function automatic logic [31:0] boot_value(input int unsigned idx);
    case (idx)
      'h40:    return 32'h05F2_0121;
      'h41:    return 32'h0000_0002;
      'h42:    return 32'h05F3_0121;
      'h43:    return 32'h05F4_0121;
      default: return 32'h0;
    endcase
  endfunction
endpackage

// File: rtl/sysctl_store.sv
module sysctl_store #(
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 512,
  localparam int IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_word
);
  import sysctl_pkg::*;

  logic [DATA_W-1:0] mem [NUM_WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_WORDS; i++) mem[i] <= DATA_W'(boot_value(i));
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_word = mem[rd_idx];

  // R3
  store_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en)) |-> mem[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/sysctl_cmd_decode.sv
module sysctl_cmd_decode #(
  parameter int DATA_W = 32,
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [DATA_W-1:0] wr_data,
  output logic              reset_req,
  output logic              off_req
);
  import sysctl_pkg::*;

  logic hit;
  assign hit = wr_en && (wr_word == WORD_W'(CMD_WORD));

  always_ff @(posedge clk) begin
    if (rst) begin
      reset_req <= 1'b0;
      off_req   <= 1'b0;
    end else begin
      reset_req <= hit && (wr_data == DATA_W'(CODE_RST_A) ||
                           wr_data == DATA_W'(CODE_RST_B));
      off_req   <= hit && (wr_data == DATA_W'(CODE_OFF));
    end
  end

  // R5
  req_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(reset_req && off_req));
endmodule

// File: rtl/sysctl_rd_port.sv
module sysctl_rd_port #(
  parameter int DATA_W = 32,
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [WORD_W-1:0] rd_word_addr,
  input  logic [DATA_W-1:0] word_in,
  output logic [DATA_W-1:0] rdata
);
  import sysctl_pkg::*;

  logic [NUM_FORCED-1:0] hits;
  logic                  force_hit;

  for (genvar g = 0; g < NUM_FORCED; g++) begin : g_force
    assign hits[g] = (rd_word_addr == WORD_W'(FORCED_WORDS[g]));
  end
  assign force_hit = |hits;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= word_in | (force_hit ? DATA_W'(FORCE_MASK) : '0);
    end
  end

  // R8
  forced_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_en && force_hit)) |-> rdata[29:28] == 2'b11);
  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rd_en)) |-> $stable(rdata));
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 512,
  localparam int IDX_W    = $clog2(NUM_WORDS),
  localparam int WORD_W   = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sys_reset_req,
  output logic              sys_off_req
);
  logic [WORD_W-1:0] word_addr;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] cur_word;

  assign word_addr = bus_addr[ADDR_W-1:2];
  assign idx       = word_addr[IDX_W-1:0];

  sysctl_store #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)) u_store (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .wr_idx(idx), .wr_data(bus_wdata),
    .rd_idx(idx), .rd_word(cur_word)
  );

  sysctl_cmd_decode #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_cmd (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .wr_word(word_addr),
    .wr_data(bus_wdata), .reset_req(sys_reset_req), .off_req(sys_off_req)
  );

  sysctl_rd_port #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(bus_rd), .rd_word_addr(word_addr),
    .word_in(cur_word), .rdata(bus_rdata)
  );

  // R7
  cmd_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_wr && word_addr != WORD_W'(sysctl_pkg::CMD_WORD)))
      |-> (!sys_reset_req && !sys_off_req));
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bus_wr)) |-> (!sys_reset_req && !sys_off_req));
endmodule

// File: tb/sysctl_regs_bench.sv
`timescale 1ns/1ps
module sysctl_regs_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic        bus_rd;
  logic [31:0] bus_rdata;
  logic        sys_reset_req;
  logic        sys_off_req;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [31:0] model [512];

  always #2.5 clk = ~clk;

  sysctl_regs u_sysctl_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .sys_reset_req(sys_reset_req), .sys_off_req(sys_off_req)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    logic [31:0] v;
    v = model[a[10:2]];
    if (a[11:2] == 10'h040 || a[11:2] == 10'h042 || a[11:2] == 10'h043)
      v = v | 32'h3000_0000;
    return v;
  endfunction

  // returns pulses seen in the cycle after the write edge
  task automatic do_write(input logic [11:0] a, input logic [31:0] d,
                          output logic rq, output logic oq);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    rq = sys_reset_req; oq = sys_off_req;
    model[a[10:2]] = d;
  endtask

  task automatic do_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic cmd_case(input logic [11:0] a, input logic [31:0] code);
    logic rq, oq, exp_r, exp_o;
    logic [31:0] d;
    exp_r = (a[11:2] == 10'h3C0) && (code == 1 || code == 2);
    exp_o = (a[11:2] == 10'h3C0) && (code == 3);
    do_write(a, code, rq, oq);
    chk(rq == exp_r, exp_r ? "R5 reset pulse" : "R7 no reset pulse", 32'(rq), 32'(exp_r));
    chk(oq == exp_o, exp_o ? "R6 off pulse" : "R7 no off pulse", 32'(oq), 32'(exp_o));
    @(negedge clk);
    chk(!sys_reset_req && !sys_off_req, "R5 R6 pulse one cycle",
        {30'd0, sys_reset_req, sys_off_req}, 32'd0);
    do_read(a, d);
    chk(d == code, "R7 code stored", d, code);
  endtask

  initial begin
    logic [31:0] d;
    logic rq, oq;
    rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; bus_rd = 1'b0;
    for (int i = 0; i < 512; i++) model[i] = 32'h0;
    model['h40] = 32'h05F2_0121; model['h41] = 32'h0000_0002;
    model['h42] = 32'h05F3_0121; model['h43] = 32'h05F4_0121;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(bus_rdata == 0 && !sys_reset_req && !sys_off_req, "R2 outputs at reset",
        bus_rdata, 32'd0);

    // R1 explicit identification words and forced status bits
    do_read(12'h100, d); chk(d == 32'h35F2_0121, "R1 R8 word 0x100", d, 32'h35F2_0121);
    do_read(12'h104, d); chk(d == 32'h0000_0002, "R1 word 0x104", d, 32'h2);
    do_read(12'h108, d); chk(d == 32'h35F3_0121, "R1 R8 word 0x108", d, 32'h35F3_0121);
    do_read(12'h10C, d); chk(d == 32'h35F4_0121, "R1 R8 word 0x10C", d, 32'h35F4_0121);
    do_read(12'h900, d); chk(d == 32'h05F2_0121, "R8 R4 alias unforced", d, 32'h05F2_0121);

    // R2 sweep of all reset contents through all offsets
    for (int i = 0; i < 1024; i++) begin
      do_read(12'(i * 4), d);
      chk(d == exp_read(12'(i * 4)), "R2 reset sweep", d, exp_read(12'(i * 4)));
    end

    // R3 R4 write every word via alternating halves and low address bits
    for (int i = 0; i < 512; i++) begin
      logic [11:0] a;
      a = 12'((i * 4) + ((i % 2) * 12'h800) + (i % 4));
      do_write(a, 32'hA500_0000 ^ (32'(i) * 32'h0001_0203), rq, oq);
      chk(!rq && !oq, "R7 sweep writes quiet", {30'd0, rq, oq}, 32'd0);
    end
    for (int i = 0; i < 1024; i++) begin
      do_read(12'(i * 4 + (i % 4)), d);
      chk(d == exp_read(12'(i * 4)), "R3 R4 R8 readback sweep", d, exp_read(12'(i * 4)));
    end

    // R5 R6 R7 command codes
    for (int c = 0; c < 5; c++) cmd_case(12'hF00, 32'(c));
    cmd_case(12'hF03, 32'd2);
    cmd_case(12'h700, 32'd1);
    cmd_case(12'h700, 32'd3);
    cmd_case(12'hF04, 32'd3);

    // R9 read data holds without a read strobe
    do_read(12'h104, d);
    repeat (4) @(negedge clk);
    chk(bus_rdata == model['h41], "R9 rdata holds", bus_rdata, model['h41]);

    // R10 same-cycle read and write
    @(negedge clk);
    bus_addr = 12'h240; bus_wdata = 32'hDEAD_BEEF; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    chk(bus_rdata == model['h90], "R10 collision returns old", bus_rdata, model['h90]);
    model['h90] = 32'hDEAD_BEEF;
    do_read(12'h240, d);
    chk(d == 32'hDEAD_BEEF, "R10 new value after collision", d, 32'hDEAD_BEEF);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'd1, 32'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule